// File: doc/BRIEF.md
# Coherent Port Burst Compliance Checker

This block is a passive observer placed on the address and write-data channels of an AXI-style path into a cache-coherent accelerator port. At every address handshake it sorts the burst into one of two fast shapes or into the slow class. It reports that class one cycle later, and it counts fast and slow bursts in two saturating counters. It never drives or stalls the traffic, and it does not model the cache.

Two fast shapes exist, and both use four beats of eight bytes. The wrapping shape needs an address aligned to 8 bytes. The incrementing shape needs only 4-byte alignment. The downstream cache takes any fast-shape write as a full-line write, so a fast-shape write with a cleared byte strobe on any beat is a data-corruption hazard, and the block records it. The block also records an exclusive access to coherent memory and any locked access. These three conditions go into sticky flags. Software reads them through a small status port and clears them by writing ones.

Write data beats are matched in order to write addresses that are already accepted. A beat may arrive in the same cycle as its own address. Up to `WQ_DEPTH` writes may be waiting for data.

Top module: `burst_chk`

## Requirements
- R1: A burst with len 3 (four beats), size 3 (eight bytes), burst code 2'b10 (wrap) and address bits [2:0] all zero is classified as code 2'b01.
- R2: A burst with len 3, size 3, burst code 2'b01 (incrementing) and address bits [1:0] zero is classified as code 2'b10. This includes addresses that are also 8-byte aligned.
- R3: Every other burst is classified as code 2'b00 (slow). This covers a wrap at a 4-byte-only alignment, any misaligned incrementing burst, any other size or length, and the fixed code 2'b00.
- R4: Each address handshake (valid and ready both high) gives exactly one pulse on `wr_cls_valid` or `rd_cls_valid`, in the cycle after the handshake, with the class on `wr_cls` or `rd_cls`.
- R5: A data beat of a fast-class write whose strobe is not all ones sets flag bit 0. Partial strobes on a slow-class write leave that bit clear.
- R6: A handshake with lock code 2'b01 (exclusive) and the coherent indicator high sets flag bit 1. With the indicator low, the access sets no flag.
- R7: A handshake with lock code 2'b10 (locked) sets flag bit 2, whatever the coherent indicator says.
- R8: Flags are sticky. They are read at status address 0, bits [2:0]. A write to status address 0 clears each flag whose mask bit is one. A flag set in the same cycle as its clear stays set.
- R9: Status address 1 holds the count of fast-class handshakes and address 2 the count of slow-class handshakes. Both read and write channels are counted, and two handshakes in one cycle add two. Each counter stops at 2^CNT_W-1.
- R10: Write data beats are checked against the oldest accepted write whose last beat has not passed. The same-cycle case (address and first beat together) uses that address's class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid (observed) |
| aw_ready | input | 1 | Write address ready (observed) |
| aw_addr_lo | input | 3 | Write address bits [2:0] |
| aw_len | input | 8 | Write burst length minus one |
| aw_size | input | 3 | Write beat size code |
| aw_burst | input | 2 | Write burst type code |
| aw_lock | input | 2 | Write lock code: 01 exclusive, 10 locked |
| aw_coherent | input | 1 | Write address lies in coherent memory |
| w_valid | input | 1 | Write data valid (observed) |
| w_ready | input | 1 | Write data ready (observed) |
| w_strb | input | DATA_W/8 | Write byte strobes |
| w_last | input | 1 | Last write beat |
| ar_valid | input | 1 | Read address valid (observed) |
| ar_ready | input | 1 | Read address ready (observed) |
| ar_addr_lo | input | 3 | Read address bits [2:0] |
| ar_len | input | 8 | Read burst length minus one |
| ar_size | input | 3 | Read beat size code |
| ar_burst | input | 2 | Read burst type code |
| ar_lock | input | 2 | Read lock code |
| ar_coherent | input | 1 | Read address lies in coherent memory |
| st_wr_en | input | 1 | Status write strobe |
| st_addr | input | 2 | Status address |
| st_clr_mask | input | 3 | Write-one-to-clear mask for the flags |
| wr_cls_valid | output | 1 | Write class report pulse |
| wr_cls | output | 2 | Write class code |
| rd_cls_valid | output | 1 | Read class report pulse |
| rd_cls | output | 2 | Read class code |
| err_flags | output | 3 | Sticky flags: [0] strobe hazard, [1] coherent exclusive, [2] locked |
| st_rdata | output | 32 | Status read data (combinational on st_addr) |

## Verification
The assertions check some rules on every cycle. A fast class must agree with the alignment and burst code of the handshake that produced it. Every handshake must be followed by its report pulse. Each flag event must raise its flag on the next edge. A flag must stay set unless its mask bit clears it. The counters must never go down, and a saturated counter must stay at its maximum. The write queue must never take an address when it is full. Other behaviour needs the bench's scenarios. These include the exact class codes for the misaligned, wrong-size and fixed variants, and the way queued writes pair with their data when several are outstanding. They also include the case where a clear and a new event meet in one cycle, and the final counter values before and after saturation.

// File: rtl/burst_chk_pkg.sv
package burst_chk_pkg;

  typedef enum logic [1:0] {
    CLS_SLOW     = 2'b00,
    CLS_EFF_WRAP = 2'b01,
    CLS_EFF_INCR = 2'b10
  } burst_cls_e;

  localparam logic [1:0] BT_INCR = 2'b01;
  localparam logic [1:0] BT_WRAP = 2'b10;

  localparam logic [1:0] LK_EXCL   = 2'b01;
  localparam logic [1:0] LK_LOCKED = 2'b10;

  localparam logic [2:0] FAST_SIZE = 3'd3;
  localparam logic [7:0] FAST_LEN  = 8'd3;

  localparam int FLG_STRB = 0;
  localparam int FLG_EXCL = 1;
  localparam int FLG_LOCK = 2;
  localparam int NFLG     = 3;

  function automatic burst_cls_e classify_shape(
    input logic [2:0] addr_lo,
    input logic [7:0] len,
    input logic [2:0] size,
    input logic [1:0] burst
  );
    logic geom_ok;
    geom_ok = (size == FAST_SIZE) && (len == FAST_LEN);
    if (geom_ok && burst == BT_WRAP && addr_lo == 3'b000)
      return CLS_EFF_WRAP;
    else if (geom_ok && burst == BT_INCR && addr_lo[1:0] == 2'b00)
      return CLS_EFF_INCR;
    else
      return CLS_SLOW;
  endfunction

endpackage

// File: rtl/burst_chk_classify.sv
module burst_chk_classify
  import burst_chk_pkg::*;
(
  input  logic [2:0]  addr_lo,
  input  logic [7:0]  len,
  input  logic [2:0]  size,
  input  logic [1:0]  burst,
  input  logic [1:0]  lock,
  input  logic        coherent,
  output burst_cls_e  cls,
  output logic        is_fast,
  output logic        excl_hit,
  output logic        lock_hit
);

  always_comb begin
    cls      = classify_shape(addr_lo, len, size, burst);
    is_fast  = (cls != CLS_SLOW);
    excl_hit = (lock == LK_EXCL) && coherent;
    lock_hit = (lock == LK_LOCKED);
  end

endmodule

// File: rtl/burst_chk_wtrack.sv
module burst_chk_wtrack #(
  parameter int DEPTH  = 4,
  parameter int STRB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_fire,
  input  logic              aw_fast,
  input  logic              w_fire,
  input  logic              w_last,
  input  logic [STRB_W-1:0] w_strb,
  output logic              strb_hazard
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W:0] DEPTH_C = (PTR_W+1)'(DEPTH);

  logic [DEPTH-1:0] fast_mem;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [PTR_W:0]   cnt;

  logic empty, full, last_fire, push, pop, owned, owner_fast;

  always_comb begin
    empty      = (cnt == '0);
    full       = (cnt == DEPTH_C);
    last_fire  = w_fire && w_last;
    push       = aw_fire && !(empty && last_fire);
    pop        = last_fire && !empty;
    owned      = !empty || aw_fire;
    owner_fast = empty ? aw_fast : fast_mem[rd_ptr];
    strb_hazard = w_fire && owned && owner_fast && (w_strb != {STRB_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_mem <= '0;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      cnt      <= '0;
    end else begin
      if (push) begin
        fast_mem[wr_ptr] <= aw_fast;
        wr_ptr           <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_WQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R10

endmodule

// File: rtl/burst_chk_regs.sv
module burst_chk_regs
  import burst_chk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLG-1:0] ev_set,
  input  logic [1:0]      fast_inc,
  input  logic [1:0]      slow_inc,
  input  logic            st_wr_en,
  input  logic [1:0]      st_addr,
  input  logic [NFLG-1:0] st_clr_mask,
  output logic [NFLG-1:0] flags,
  output logic [31:0]     st_rdata
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] fast_cnt, slow_cnt;
  logic [NFLG-1:0]  clr_vec;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [1:0] inc);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {{(CNT_W-1){1'b0}}, inc};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  always_comb begin
    clr_vec = (st_wr_en && st_addr == 2'd0) ? st_clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= '0;
      fast_cnt <= '0;
      slow_cnt <= '0;
    end else begin
      flags    <= (flags & ~clr_vec) | ev_set;
      fast_cnt <= sat_add(fast_cnt, fast_inc);
      slow_cnt <= sat_add(slow_cnt, slow_inc);
    end
  end

  always_comb begin
    st_rdata = '0;
    case (st_addr)
      2'd0:    st_rdata[NFLG-1:0]  = flags;
      2'd1:    st_rdata[CNT_W-1:0] = fast_cnt;
      2'd2:    st_rdata[CNT_W-1:0] = slow_cnt;
      default: st_rdata = '0;
    endcase
  end

  for (genvar gi = 0; gi < NFLG; gi++) begin : g_flag_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[gi] && !clr_vec[gi]) |=> flags[gi]); // R8
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_set[gi] |=> flags[gi]); // R8
  end

  AST_FAST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fast_cnt >= $past(fast_cnt)); // R9
  AST_SLOW_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    slow_cnt >= $past(slow_cnt)); // R9
  AST_SLOW_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_cnt == CNT_MAX) |=> (slow_cnt == CNT_MAX)); // R9

endmodule

// File: rtl/burst_chk.sv
module burst_chk
  import burst_chk_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int CNT_W    = 16,
  parameter int WQ_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                aw_valid,
  input  logic                aw_ready,
  input  logic [2:0]          aw_addr_lo,
  input  logic [7:0]          aw_len,
  input  logic [2:0]          aw_size,
  input  logic [1:0]          aw_burst,
  input  logic [1:0]          aw_lock,
  input  logic                aw_coherent,
  input  logic                w_valid,
  input  logic                w_ready,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_last,
  input  logic                ar_valid,
  input  logic                ar_ready,
  input  logic [2:0]          ar_addr_lo,
  input  logic [7:0]          ar_len,
  input  logic [2:0]          ar_size,
  input  logic [1:0]          ar_burst,
  input  logic [1:0]          ar_lock,
  input  logic                ar_coherent,
  input  logic                st_wr_en,
  input  logic [1:0]          st_addr,
  input  logic [2:0]          st_clr_mask,
  output logic                wr_cls_valid,
  output logic [1:0]          wr_cls,
  output logic                rd_cls_valid,
  output logic [1:0]          rd_cls,
  output logic [2:0]          err_flags,
  output logic [31:0]         st_rdata
);

  localparam int STRB_W = DATA_W / 8;

  logic aw_fire, ar_fire, w_fire;
  burst_cls_e aw_cls, ar_cls;
  logic aw_fast, ar_fast, aw_excl, ar_excl, aw_lk, ar_lk;
  logic ev_strb, ev_excl, ev_lock;
  logic [NFLG-1:0] ev_set;
  logic [1:0] fast_inc, slow_inc;

  always_comb begin
    aw_fire = aw_valid && aw_ready;
    ar_fire = ar_valid && ar_ready;
    w_fire  = w_valid && w_ready;
  end

  burst_chk_classify u_cls_wr (
    .addr_lo (aw_addr_lo), .len (aw_len), .size (aw_size), .burst (aw_burst),
    .lock (aw_lock), .coherent (aw_coherent),
    .cls (aw_cls), .is_fast (aw_fast), .excl_hit (aw_excl), .lock_hit (aw_lk)
  );

  burst_chk_classify u_cls_rd (
    .addr_lo (ar_addr_lo), .len (ar_len), .size (ar_size), .burst (ar_burst),
    .lock (ar_lock), .coherent (ar_coherent),
    .cls (ar_cls), .is_fast (ar_fast), .excl_hit (ar_excl), .lock_hit (ar_lk)
  );

  burst_chk_wtrack #(.DEPTH (WQ_DEPTH), .STRB_W (STRB_W)) u_wtrack (
    .clk (clk), .rst_n (rst_n),
    .aw_fire (aw_fire), .aw_fast (aw_fast),
    .w_fire (w_fire), .w_last (w_last), .w_strb (w_strb),
    .strb_hazard (ev_strb)
  );

  always_comb begin
    ev_excl = (aw_fire && aw_excl) || (ar_fire && ar_excl);
    ev_lock = (aw_fire && aw_lk)   || (ar_fire && ar_lk);
    ev_set  = '0;
    ev_set[FLG_STRB] = ev_strb;
    ev_set[FLG_EXCL] = ev_excl;
    ev_set[FLG_LOCK] = ev_lock;
    fast_inc = {1'b0, aw_fire && aw_fast}  + {1'b0, ar_fire && ar_fast};
    slow_inc = {1'b0, aw_fire && !aw_fast} + {1'b0, ar_fire && !ar_fast};
  end

  burst_chk_regs #(.CNT_W (CNT_W)) u_regs (
    .clk (clk), .rst_n (rst_n),
    .ev_set (ev_set), .fast_inc (fast_inc), .slow_inc (slow_inc),
    .st_wr_en (st_wr_en), .st_addr (st_addr), .st_clr_mask (st_clr_mask),
    .flags (err_flags), .st_rdata (st_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cls_valid <= 1'b0;
      rd_cls_valid <= 1'b0;
      wr_cls       <= CLS_SLOW;
      rd_cls       <= CLS_SLOW;
    end else begin
      wr_cls_valid <= aw_fire;
      rd_cls_valid <= ar_fire;
      if (aw_fire) wr_cls <= aw_cls;
      if (ar_fire) rd_cls <= ar_cls;
    end
  end

  AST_WRAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cls_valid && wr_cls == CLS_EFF_WRAP) |->
      ($past(aw_addr_lo) == 3'b000 && $past(aw_burst) == BT_WRAP)); // R1
  AST_INCR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cls_valid && rd_cls == CLS_EFF_INCR) |->
      ($past(ar_addr_lo[1:0]) == 2'b00 && $past(ar_burst) == BT_INCR)); // R2
  AST_WR_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |=> wr_cls_valid); // R4
  AST_RD_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |=> rd_cls_valid); // R4
  AST_HAZARD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strb |=> err_flags[FLG_STRB]); // R5
  AST_EXCL_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_excl |-> ((aw_fire && aw_coherent) || (ar_fire && ar_coherent))); // R6
  AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_fire && ar_lock == LK_LOCKED) |=> err_flags[FLG_LOCK]); // R7

endmodule

// File: tb/burst_chk_tb.sv
module burst_chk_tb;

  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aw_valid = 0, aw_ready = 0, aw_coherent = 0;
  logic [2:0] aw_addr_lo = 0, aw_size = 0;
  logic [7:0] aw_len = 0;
  logic [1:0] aw_burst = 0, aw_lock = 0;
  logic w_valid = 0, w_ready = 0, w_last = 0;
  logic [7:0] w_strb = 0;
  logic ar_valid = 0, ar_ready = 0, ar_coherent = 0;
  logic [2:0] ar_addr_lo = 0, ar_size = 0;
  logic [7:0] ar_len = 0;
  logic [1:0] ar_burst = 0, ar_lock = 0;
  logic st_wr_en = 0;
  logic [1:0] st_addr = 0;
  logic [2:0] st_clr_mask = 0;
  logic wr_cls_valid, rd_cls_valid;
  logic [1:0] wr_cls, rd_cls;
  logic [2:0] err_flags;
  logic [31:0] st_rdata;

  int n_chk = 0, n_fail = 0;
  int exp_fast = 0, exp_slow = 0;
  bit done = 0;
  logic [1:0] wr_q[$];
  logic [1:0] rd_q[$];

  always #5 clk = ~clk;

  burst_chk #(.CNT_W (CNT_W)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .aw_valid (aw_valid), .aw_ready (aw_ready), .aw_addr_lo (aw_addr_lo),
    .aw_len (aw_len), .aw_size (aw_size), .aw_burst (aw_burst),
    .aw_lock (aw_lock), .aw_coherent (aw_coherent),
    .w_valid (w_valid), .w_ready (w_ready), .w_strb (w_strb), .w_last (w_last),
    .ar_valid (ar_valid), .ar_ready (ar_ready), .ar_addr_lo (ar_addr_lo),
    .ar_len (ar_len), .ar_size (ar_size), .ar_burst (ar_burst),
    .ar_lock (ar_lock), .ar_coherent (ar_coherent),
    .st_wr_en (st_wr_en), .st_addr (st_addr), .st_clr_mask (st_clr_mask),
    .wr_cls_valid (wr_cls_valid), .wr_cls (wr_cls),
    .rd_cls_valid (rd_cls_valid), .rd_cls (rd_cls),
    .err_flags (err_flags), .st_rdata (st_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model of the shape rules, written from the requirements.
  function automatic logic [1:0] ref_cls(input int addr, input int len, input int size,
                                         input int bt);
    bit four_by_eight;
    four_by_eight = (len == 3) && (size == 3);
    if (!four_by_eight) return 2'b00;
    if (bt == 2) return (addr % 8 == 0) ? 2'b01 : 2'b00;
    if (bt == 1) return (addr % 4 == 0) ? 2'b10 : 2'b00;
    return 2'b00;
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic note_count(input logic [1:0] c);
    if (c != 2'b00) exp_fast = sat(exp_fast + 1);
    else            exp_slow = sat(exp_slow + 1);
  endtask

  task automatic aw_only(input int addr, input int len, input int size, input int bt,
                         input int lk, input bit coh);
    logic [1:0] c;
    c = ref_cls(addr, len, size, bt);
    wr_q.push_back(c);
    note_count(c);
    @(negedge clk);
    aw_addr_lo = addr[2:0]; aw_len = len[7:0]; aw_size = size[2:0];
    aw_burst = bt[1:0]; aw_lock = lk[1:0]; aw_coherent = coh;
    aw_valid = 1; aw_ready = 1;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0;
  endtask

  task automatic w_burst(input int beats, input int bad_beat, input logic [7:0] bad_strb);
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      w_valid = 1; w_ready = 1;
      w_strb = (b == bad_beat) ? bad_strb : 8'hFF;
      w_last = (b == beats - 1);
    end
    @(negedge clk);
    w_valid = 0; w_ready = 0; w_last = 0;
  endtask

  task automatic do_write(input int addr, input int len, input int size, input int bt,
                          input int lk, input bit coh, input int bad_beat,
                          input logic [7:0] bad_strb);
    aw_only(addr, len, size, bt, lk, coh);
    w_burst(len + 1, bad_beat, bad_strb);
  endtask

  // Address and first data beat in one cycle.
  task automatic write_same_cycle(input int addr, input int bt, input int bad_beat,
                                  input logic [7:0] bad_strb);
    logic [1:0] c;
    c = ref_cls(addr, 3, 3, bt);
    wr_q.push_back(c);
    note_count(c);
    @(negedge clk);
    aw_addr_lo = addr[2:0]; aw_len = 3; aw_size = 3; aw_burst = bt[1:0];
    aw_lock = 0; aw_coherent = 0; aw_valid = 1; aw_ready = 1;
    w_valid = 1; w_ready = 1; w_last = 0;
    w_strb = (bad_beat == 0) ? bad_strb : 8'hFF;
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      aw_valid = 0; aw_ready = 0;
      w_strb = (b == bad_beat) ? bad_strb : 8'hFF;
      w_last = (b == 3);
    end
    @(negedge clk);
    w_valid = 0; w_ready = 0; w_last = 0;
  endtask

  task automatic do_read(input int addr, input int len, input int size, input int bt,
                         input int lk, input bit coh);
    logic [1:0] c;
    c = ref_cls(addr, len, size, bt);
    rd_q.push_back(c);
    note_count(c);
    @(negedge clk);
    ar_addr_lo = addr[2:0]; ar_len = len[7:0]; ar_size = size[2:0];
    ar_burst = bt[1:0]; ar_lock = lk[1:0]; ar_coherent = coh;
    ar_valid = 1; ar_ready = 1;
    @(negedge clk);
    ar_valid = 0; ar_ready = 0;
  endtask

  task automatic w1c(input logic [2:0] mask);
    @(negedge clk);
    st_wr_en = 1; st_addr = 0; st_clr_mask = mask;
    @(negedge clk);
    st_wr_en = 0; st_clr_mask = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    st_addr = a;
    #1;
    chk(req, st_rdata, exp);
  endtask

  // Scoreboard monitor: pops expected classes as reports appear.
  always @(negedge clk) begin
    if (rst_n && wr_cls_valid) begin
      if (wr_q.size() == 0) chk("R4 unexpected write report", 1, 0);
      else chk("R1/R2/R3 write class", {30'b0, wr_cls}, {30'b0, wr_q.pop_front()});
    end
    if (rst_n && rd_cls_valid) begin
      if (rd_q.size() == 0) chk("R4 unexpected read report", 1, 0);
      else chk("R1/R2/R3 read class", {30'b0, rd_cls}, {30'b0, rd_q.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state
    @(negedge clk);
    chk("R4 reset wr report", {31'b0, wr_cls_valid}, 0);
    rd_reg(0, 0, "R8 reset flags");
    rd_reg(1, 0, "R9 reset fast count");
    rd_reg(2, 0, "R9 reset slow count");

    // R1, R2 fast shapes with full strobes
    do_write(0, 3, 3, 2, 0, 0, -1, 8'hFF);
    do_write(4, 3, 3, 1, 0, 0, -1, 8'hFF);
    do_write(8, 3, 3, 1, 0, 0, -1, 8'hFF);
    rd_reg(0, 0, "R5 full strobes no hazard");

    // R3 slow variants
    do_read(4, 3, 3, 2, 0, 0);   // wrap at 4-byte alignment
    do_read(2, 3, 3, 1, 0, 0);   // misaligned incr
    do_read(0, 3, 2, 1, 0, 0);   // 4-byte beats
    do_read(0, 7, 3, 2, 0, 0);   // eight beats
    do_read(0, 3, 3, 0, 0, 0);   // fixed

    // R5 partial strobe on slow write is ignored
    do_write(2, 3, 3, 1, 0, 0, 1, 8'h0F);
    rd_reg(0, 0, "R5 slow partial ignored");
    // R5 partial strobe on fast write
    do_write(0, 3, 3, 2, 0, 0, 2, 8'hF0);
    rd_reg(0, 1, "R5 fast partial hazard");
    w1c(3'b001);
    rd_reg(0, 0, "R8 clear hazard");

    // R10 same-cycle address and first beat
    write_same_cycle(0, 1, 0, 8'h7F);
    rd_reg(0, 1, "R10 same-cycle hazard");
    w1c(3'b001);

    // R10 two outstanding writes, data in order
    aw_only(2, 3, 3, 1, 0, 0);
    aw_only(0, 3, 3, 2, 0, 0);
    w_burst(4, 0, 8'h00);
    rd_reg(0, 0, "R10 first queued slow write");
    w_burst(4, 3, 8'hFE);
    rd_reg(0, 1, "R10 second queued fast write");
    w1c(3'b111);
    rd_reg(0, 0, "R8 clear all");

    // R6 exclusive
    do_read(0, 3, 3, 1, 1, 1);
    rd_reg(0, 2, "R6 coherent exclusive flagged");
    w1c(3'b010);
    do_write(0, 3, 3, 2, 1, 0, -1, 8'hFF);
    rd_reg(0, 0, "R6 non-coherent exclusive allowed");

    // R7 locked
    do_read(0, 0, 3, 0, 2, 0);
    rd_reg(0, 4, "R7 locked flagged");
    fork
      do_read(0, 0, 3, 0, 2, 1);
      w1c(3'b100);
    join
    rd_reg(0, 4, "R8 set wins over clear");
    w1c(3'b100);
    rd_reg(0, 0, "R8 clear locked");

    // R9 concurrent handshakes on both channels
    fork
      do_write(1, 0, 3, 1, 0, 0, -1, 8'hFF);
      do_read(1, 0, 3, 1, 0, 0);
    join
    rd_reg(1, exp_fast, "R9 fast count");
    rd_reg(2, exp_slow, "R9 slow count");

    // R9 saturation
    for (int i = 0; i < 10; i++) do_read(3, 0, 0, 1, 0, 0);
    rd_reg(2, CMAX, "R9 slow saturated");
    chk("R9 model saturated", exp_slow, CMAX);
    rd_reg(1, exp_fast, "R9 fast unchanged by slow");

    repeat (4) @(negedge clk);
    chk("R4 all write reports seen", wr_q.size(), 0);
    chk("R4 all read reports seen", rd_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule